// File: doc/BRIEF.md
# Bus Clock Source Fallback Controller

This controller sits in the bus clock domain. It decides whether the bus clock comes from the PLL output or from the qualified external oscillator. Software asks for a source through a select bit. A 0 requests the oscillator path and a 1 requests the PLL path. The hardware grants the oscillator path only when the PLL is locked and the oscillator is qualified. If qualification later drops while the oscillator is in use, the hardware moves back to the PLL path without any software action.

The block also drives the division setting for the PLL output path. While the PLL is not locked, the divider is forced to a fixed fallback factor (divide by four by default). Once lock returns, the software-configured factor applies again.

Two sticky flags record every change of the lock status and of the qualification status. Software clears each flag by writing a 1 to it. Each flag has its own interrupt enable bit. The interrupt line is a registered combination of the enabled flags. The glitch-free clock multiplexer, the PLL, the VCO and the spike filter sit outside this block.

Top module: `clksrc_fallback_ctrl`

## Requirements
- R1: After reset, `sel_o` is 1, `flags_o` is 0, `ie_o` is 0, `irq_o` is 0 and `lock_o` and `oscq_o` are 0.
- R2: `sel_o` = 1 means the PLL path and 0 means the oscillator path. A write (`sel_wr_i` = 1) with `sel_wdata_i` = 1 makes `sel_o` 1 at the next clock edge.
- R3: A write with `sel_wdata_i` = 0 changes `sel_o` to 0 at the next edge only if `lock_o` and `oscq_o` are both 1 in the write cycle. Otherwise the write is ignored and `sel_o` keeps its value.
- R4: `lock_o` follows `pll_lock_i` one cycle later. `oscq_o` follows `osc_ok_i` one cycle later, except that when `filt_en_i` is 1 and `pll_lock_i` is 0, `oscq_o` becomes 0 at the next edge whatever `osc_ok_i` is.
- R5: `sel_o` becomes 1 at the same edge where `oscq_o` becomes 0. This hardware fallback overrides a software write of 0 in that cycle.
- R6: `div_o` equals `FALLBACK_DIV` (default 4) while `lock_o` is 0. It equals `div_cfg_i` while `lock_o` is 1.
- R7: `flags_o[0]` is set at every edge where `lock_o` changes, and `flags_o[1]` at every edge where `oscq_o` changes. Both rising and falling changes set the flag. Flags hold their value until cleared.
- R8: When `flg_clr_i` is 1, each bit of `flg_wdata_i` that is 1 clears the matching flag. Bits that are 0 have no effect. A new status change in the same cycle wins over the clear.
- R9: `irq_o` is 1 in the cycle after any flag and its enable were both 1, and 0 in the cycle after none were.
- R10: When `ie_wr_i` is 1, `ie_o` takes `ie_wdata_i` at the next edge. Bit 0 enables the lock flag and bit 1 enables the oscillator flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| filt_en_i | input | 1 | Oscillator filter enabled; ties qualification to PLL lock |
| pll_lock_i | input | 1 | PLL lock status |
| osc_ok_i | input | 1 | Oscillator qualification from the filter |
| div_cfg_i | input | DIV_W | Normal PLL output division factor |
| sel_wr_i | input | 1 | Software write strobe for the select bit |
| sel_wdata_i | input | 1 | Requested select value |
| flg_clr_i | input | 1 | Flag clear strobe |
| flg_wdata_i | input | 2 | Write-1-to-clear mask for the flags |
| ie_wr_i | input | 1 | Interrupt enable write strobe |
| ie_wdata_i | input | 2 | New interrupt enable bits |
| sel_o | output | 1 | Effective select (1 = PLL, 0 = oscillator) |
| div_o | output | DIV_W | Division factor for the PLL output path |
| lock_o | output | 1 | Registered lock status |
| oscq_o | output | 1 | Registered, lock-gated oscillator qualification |
| flags_o | output | 2 | Sticky change flags (bit 0 lock, bit 1 oscillator) |
| ie_o | output | 2 | Interrupt enables |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The select logic is driven with random writes against randomly toggling lock and qualification inputs. This separates grants from refusals and shows whether a fallback in the same cycle overrides a write of 0. Directed sequences cover three cases. In the first, a valid switch to the oscillator is followed by a loss of qualification, which exercises the automatic return. In the second, a filter-enabled lock loss with the oscillator still reporting good separates the gated qualification from the raw input. In the third, clears that coincide with fresh status edges show that a set wins over a clear. A random divider configuration, checked in both lock states, shows which setting reaches `div_o`.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
   localparam int unsigned N_STAT = 2;
   typedef enum int unsigned {
      ST_LOCK = 0,
      ST_OSC  = 1
   } stat_idx_e;
   typedef logic [N_STAT-1:0] stat_vec_t;
endpackage

// File: rtl/clksrc_status.sv
module clksrc_status
   import clksrc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      filt_en_i,
   input  logic      pll_lock_i,
   input  logic      osc_ok_i,
   output logic      lock_q_o,
   output logic      oscq_q_o,
   output logic      oscq_d_o,
   output stat_vec_t chg_o
);
   logic lock_q, oscq_q, oscq_d;

   // qualification is void while the filter runs without a locked reference
   assign oscq_d = osc_ok_i & (~filt_en_i | pll_lock_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         oscq_q <= 1'b0;
      end else begin
         lock_q <= pll_lock_i;
         oscq_q <= oscq_d;
      end
   end

   always_comb begin
      chg_o          = '0;
      chg_o[ST_LOCK] = pll_lock_i ^ lock_q;
      chg_o[ST_OSC]  = oscq_d ^ oscq_q;
   end

   assign lock_q_o = lock_q;
   assign oscq_q_o = oscq_q;
   assign oscq_d_o = oscq_d;

   // R4
   filt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_en_i && !pll_lock_i) |=> !oscq_q);
endmodule

// File: rtl/clksrc_select.sv
module clksrc_select #(
   parameter logic SEL_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_q_i,
   input  logic oscq_q_i,
   input  logic oscq_d_i,
   input  logic wr_i,
   input  logic wdata_i,
   output logic sel_o
);
   logic sel_q, sel_d, grant;

   assign grant = lock_q_i & oscq_q_i;

   always_comb begin
      sel_d = sel_q;
      if (wr_i) begin
         if (wdata_i)    sel_d = 1'b1;
         else if (grant) sel_d = 1'b0;
      end
      if (!oscq_d_i) sel_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= SEL_RST;
      else        sel_q <= sel_d;
   end

   assign sel_o = sel_q;

   // R5
   fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_q && !oscq_d_i) |=> sel_q);
   // R3
   sw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !(lock_q_i && oscq_q_i)) |=> sel_q);
endmodule

// File: rtl/clksrc_flags.sv
module clksrc_flags
   import clksrc_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  stat_vec_t set_i,
   input  logic      clr_i,
   input  stat_vec_t clr_mask_i,
   input  logic      ie_wr_i,
   input  stat_vec_t ie_wdata_i,
   output stat_vec_t flg_o,
   output stat_vec_t ie_o,
   output logic      irq_o
);
   stat_vec_t flg_q, ie_q;
   logic      irq_d;

   for (genvar i = 0; i < N_STAT; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          flg_q[i] <= 1'b0;
         else if (set_i[i])                   flg_q[i] <= 1'b1;
         else if (clr_i && clr_mask_i[i])     flg_q[i] <= 1'b0;
      end
      // R7
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flg_q[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ie_q <= '0;
      else if (ie_wr_i) ie_q <= ie_wdata_i;
   end

   assign irq_d = |(flg_q & ie_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq_o = irq_q;
      // R9
      irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (|(flg_q & ie_q)) |=> irq_o);
   end else begin : g_irq_comb
      assign irq_o = irq_d;
   end

   assign flg_o = flg_q;
   assign ie_o  = ie_q;
endmodule

// File: rtl/clksrc_fallback_ctrl.sv
module clksrc_fallback_ctrl
   import clksrc_pkg::*;
#(
   parameter int unsigned DIV_W        = 6,
   parameter int unsigned FALLBACK_DIV = 4,
   parameter logic        SEL_RST      = 1'b1,
   parameter bit          IRQ_REG      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             filt_en_i,
   input  logic             pll_lock_i,
   input  logic             osc_ok_i,
   input  logic [DIV_W-1:0] div_cfg_i,
   input  logic             sel_wr_i,
   input  logic             sel_wdata_i,
   input  logic             flg_clr_i,
   input  logic [1:0]       flg_wdata_i,
   input  logic             ie_wr_i,
   input  logic [1:0]       ie_wdata_i,
   output logic             sel_o,
   output logic [DIV_W-1:0] div_o,
   output logic             lock_o,
   output logic             oscq_o,
   output logic [1:0]       flags_o,
   output logic [1:0]       ie_o,
   output logic             irq_o
);
   localparam logic [DIV_W-1:0] FB_DIV = DIV_W'(FALLBACK_DIV);

   if (DIV_W < 2 || DIV_W > 16) begin : g_bad_w
      $error("DIV_W out of range");
   end
   if (FALLBACK_DIV == 0 || FALLBACK_DIV >= (1 << DIV_W)) begin : g_bad_fb
      $error("FALLBACK_DIV does not fit DIV_W");
   end
   if (N_STAT != 2) begin : g_bad_n
      $error("flag count must match port width");
   end

   logic      lock_q, oscq_q, oscq_d;
   stat_vec_t chg;

   clksrc_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .filt_en_i  (filt_en_i),
      .pll_lock_i (pll_lock_i),
      .osc_ok_i   (osc_ok_i),
      .lock_q_o   (lock_q),
      .oscq_q_o   (oscq_q),
      .oscq_d_o   (oscq_d),
      .chg_o      (chg)
   );

   clksrc_select #(.SEL_RST(SEL_RST)) u_select (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock_q_i (lock_q),
      .oscq_q_i (oscq_q),
      .oscq_d_i (oscq_d),
      .wr_i     (sel_wr_i),
      .wdata_i  (sel_wdata_i),
      .sel_o    (sel_o)
   );

   clksrc_flags #(.IRQ_REG(IRQ_REG)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (chg),
      .clr_i      (flg_clr_i),
      .clr_mask_i (flg_wdata_i),
      .ie_wr_i    (ie_wr_i),
      .ie_wdata_i (ie_wdata_i),
      .flg_o      (flags_o),
      .ie_o       (ie_o),
      .irq_o      (irq_o)
   );

   assign div_o  = lock_q ? div_cfg_i : FB_DIV;
   assign lock_o = lock_q;
   assign oscq_o = oscq_q;

   // R6
   div_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pll_lock_i) |=> (div_o == FB_DIV));
endmodule

// File: tb/test_clksrc_fallback_ctrl.sv
module test_clksrc_fallback_ctrl;
   localparam int DIV_W = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic filt_en, lock_in, osc_in, sel_wr, sel_wd, fclr, iewr;
   logic [DIV_W-1:0] div_cfg;
   logic [1:0] fwd, iewd;
   logic sel, lock, oscq, irq;
   logic [DIV_W-1:0] div;
   logic [1:0] flg, ie;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // model state
   logic m_lock, m_oscq, m_sel, m_irq;
   logic [1:0] m_flg, m_ie;

   always #10 clk = ~clk;

   clksrc_fallback_ctrl #(.DIV_W(DIV_W)) i_clksrc_fallback_ctrl (
      .clk(clk), .rst_n(rst_n), .filt_en_i(filt_en), .pll_lock_i(lock_in),
      .osc_ok_i(osc_in), .div_cfg_i(div_cfg), .sel_wr_i(sel_wr),
      .sel_wdata_i(sel_wd), .flg_clr_i(fclr), .flg_wdata_i(fwd),
      .ie_wr_i(iewr), .ie_wdata_i(iewd), .sel_o(sel), .div_o(div),
      .lock_o(lock), .oscq_o(oscq), .flags_o(flg), .ie_o(ie), .irq_o(irq));

   function automatic logic exp_oscq(logic f, logic l, logic o);
      return o & (~f | l);
   endfunction

   function automatic logic exp_sel(logic cur, logic ml, logic mo, logic nq,
                                    logic wr, logic wd);
      logic r;
      r = cur;
      if (wr) begin
         if (wd) r = 1'b1;
         else if (ml && mo) r = 1'b0;
      end
      if (!nq) r = 1'b1;
      return r;
   endfunction

   function automatic logic [DIV_W-1:0] exp_div(logic l, logic [DIV_W-1:0] c);
      return l ? c : DIV_W'(4);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk("R2/R3/R5 sel", int'(sel), int'(m_sel));
      chk("R4 lock", int'(lock), int'(m_lock));
      chk("R4 oscq", int'(oscq), int'(m_oscq));
      chk("R6 div", int'(div), int'(exp_div(m_lock, div_cfg)));
      chk("R7/R8 flags", int'(flg), int'(m_flg));
      chk("R10 ie", int'(ie), int'(m_ie));
      chk("R9 irq", int'(irq), int'(m_irq));
   endtask

   // drive one cycle at negedge, advance model across posedge, check at next negedge
   task automatic step(logic f, logic l, logic o, logic sw, logic sd,
                       logic fc, logic [1:0] fd, logic iw, logic [1:0] id);
      logic nl, no, ns, ni;
      logic [1:0] nf, nie;
      filt_en = f; lock_in = l; osc_in = o; sel_wr = sw; sel_wd = sd;
      fclr = fc; fwd = fd; iewr = iw; iewd = id;
      nl = l;
      no = exp_oscq(f, l, o);
      ns = exp_sel(m_sel, m_lock, m_oscq, no, sw, sd);
      nf = (m_flg & ~(fc ? fd : 2'b00)) | {no ^ m_oscq, nl ^ m_lock};
      nie = iw ? id : m_ie;
      ni = |(m_flg & m_ie);
      @(posedge clk);
      m_lock = nl; m_oscq = no; m_sel = ns; m_flg = nf; m_ie = nie; m_irq = ni;
      @(negedge clk);
      check_all();
   endtask

   initial begin
      filt_en = 0; lock_in = 0; osc_in = 0; sel_wr = 0; sel_wd = 0;
      fclr = 0; fwd = 0; iewr = 0; iewd = 0; div_cfg = 6'd9;
      m_lock = 0; m_oscq = 0; m_sel = 1; m_flg = 0; m_ie = 0; m_irq = 0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state
      check_all();
      rst_n = 1'b1;
      @(negedge clk);
      check_all();

      // R3: write 0 refused while not locked / not qualified
      step(1, 0, 1, 1, 0, 0, 2'b00, 1, 2'b11);
      chk("R3 refused", int'(sel), 1);
      // bring up lock and qualification
      step(1, 1, 1, 0, 0, 0, 2'b00, 0, 2'b00);
      step(1, 1, 1, 0, 0, 1, 2'b11, 0, 2'b00);
      // R3: granted
      step(1, 1, 1, 1, 0, 0, 2'b00, 0, 2'b00);
      chk("R3 granted", int'(sel), 0);
      // R5: qualification lost, fallback overrides a write of 0
      step(0, 1, 0, 1, 0, 0, 2'b00, 0, 2'b00);
      chk("R5 fallback", int'(sel), 1);
      // re-grant then filter-enabled lock loss with osc still good
      step(1, 1, 1, 0, 0, 0, 2'b00, 0, 2'b00);
      step(1, 1, 1, 1, 0, 0, 2'b00, 0, 2'b00);
      step(1, 0, 1, 0, 0, 0, 2'b00, 0, 2'b00);
      chk("R4 gated oscq", int'(oscq), 0);
      chk("R5 on lock loss", int'(sel), 1);
      chk("R6 fallback div", int'(div), 4);
      // R8: clear coincides with a new lock edge, set wins
      step(1, 1, 1, 0, 0, 1, 2'b11, 0, 2'b00);
      chk("R8 set wins", int'(flg[0]), 1);
      // R2: write 1
      step(1, 1, 1, 1, 1, 0, 2'b00, 0, 2'b00);
      chk("R2 write1", int'(sel), 1);

      // random phase
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] r;
         r = $urandom;
         div_cfg = r[29:24];
         step(r[0], (r[3:1] != 3'd0), (r[6:4] != 3'd0), r[7], r[8] & r[9],
              (r[12:10] == 3'd0), r[14:13], (r[18:15] == 4'd0), r[20:19]);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule